// File: doc/BRIEF.md
# I2C Addressed Transaction Sequencer

This block runs whole addressed I2C messages on top of a byte-level bus engine. A host gives it one command: a target address in 7-bit or 10-bit form, an operation, a sub-address byte and two block lengths. The sequencer then issues the matching list of engine steps (START, byte write, byte read, STOP), one at a time. It checks every acknowledge and ends the message with a STOP. Bit timing and arbitration stay inside the engine.

Write bytes arrive on a valid/ready stream. A byte is taken only in a cycle where both `wr_valid` and `wr_ready` are high, and the producer must hold `wr_valid` and `wr_data` steady until then. Read bytes leave on a valid/ready stream. `rd_data` stays fixed while `rd_valid` is high and `rd_ready` is low, and the next engine read is not issued until the current byte has been taken. So a slow consumer stalls the bus. Status pins (`done`, `ok`, `present`, `err`) are plain levels or pulses.

Operations, on `cmd_op`:
- 0 probes the target.
- 1 writes block 1.
- 2 writes the sub-address and then block 1.
- 3 writes the sub-address and block 1, then changes direction with a repeated START and reads block 2.
- 4 writes the sub-address, then block 1 and block 2 with nothing between them.

Engine step codes on `eng_cmd_kind`: 0 START, 1 WRITE, 2 READ, 3 STOP.

Top module: `i2cseq_top`

## Requirements
- R1: In 7-bit mode (`cmd_ten`=0) the address byte is `{addr[6:0], rw}`, with rw=0 for writing and rw=1 for reading.
- R2: In 10-bit mode the sequencer first writes `{5'b11110, addr[9:8], 1'b0}` and then `addr[7:0]`, and each of the two bytes must be acknowledged. The read address sent after a repeated START is the single byte `{5'b11110, addr[9:8], 1'b1}`.
- R3: A NACK on any address byte makes the next step a STOP. The message then ends with `err`=1 and `ok`=0.
- R4: A probe (op 0) is the step list START, write-address, STOP. On `done`, `present` is 1 if the address was acknowledged and 0 if it was not. Other operations leave `present` unchanged.
- R5: Op 3 issues START, write-address, sub-address, then block 1. After that it issues a second START with no STOP before it, then the read address, block 2 as READ steps, and finally STOP.
- R6: Every READ step has `eng_cmd_nack`=0 except the last one of the block, which has `eng_cmd_nack`=1. The step after that last READ is STOP.
- R7: Op 4 writes the sub-address, then every byte of block 1 and block 2 in stream order, with no START or STOP between the blocks and a single STOP at the end.
- R8: A NACK on the sub-address or on a data byte makes the next step a STOP. The message then ends with `err`=2, and `err` keeps that value while the block is idle, until the next command is accepted.
- R9: A command is accepted only in a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high exactly when the sequencer is idle, and `cmd_valid` during a message has no effect.
- R10: A block length of zero skips that block. For op 3, a block-2 length of zero also drops the repeated START and the read address.
- R11: A write byte is consumed only on a `wr_valid`/`wr_ready` handshake. Read bytes appear in order and are held until `rd_ready`, and no READ step is issued while `rd_valid` is high.
- R12: `done` is a one-cycle pulse in the first idle cycle after the final STOP. From then until the next command, `ok` is 1 exactly when `err` is 0 (err codes: 0 none, 1 address NACK, 2 data NACK).
- R13: `eng_cmd_valid` stays high, with kind and byte unchanged, until `eng_cmd_ready`. No new step is issued before the engine has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 3 | Operation code 0..4 |
| cmd_addr | input | 10 | Target address (low 7 bits in 7-bit mode) |
| cmd_ten | input | 1 | 1 selects 10-bit addressing |
| cmd_sub | input | 8 | Sub-address byte |
| cmd_len1 | input | LEN_W | Block 1 length |
| cmd_len2 | input | LEN_W | Block 2 length |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Step request to engine |
| eng_cmd_ready | input | 1 | Engine accepts step |
| eng_cmd_kind | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| eng_cmd_byte | output | 8 | Byte for WRITE |
| eng_cmd_nack | output | 1 | For READ: answer with NACK |
| eng_rsp_valid | input | 1 | Engine finished the step |
| eng_rsp_ack | input | 1 | Slave acknowledged the written byte |
| eng_rsp_data | input | 8 | Byte received by READ |
| done | output | 1 | Message finished pulse |
| ok | output | 1 | Last message succeeded |
| present | output | 1 | Last probe was acknowledged |
| err | output | 2 | Last error code |

## Verification
The properties assume an engine that answers each accepted step exactly once, and only after it accepted that step. They also assume a write producer that, once it raises `wr_valid`, holds it and its byte until the handshake. The bench's engine model answers once per step after a programmable delay and does not send unsolicited responses. Its write driver only drops `wr_valid` after a handshake. It inserts gaps only before offering a new byte. `rd_ready` is toggled freely, because the output side carries no assumption.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [2:0] {
    OP_PROBE = 3'd0,
    OP_WRITE = 3'd1,
    OP_WSUB  = 3'd2,
    OP_SUBRD = 3'd3,
    OP_WWR   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    K_START = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2,
    K_STOP  = 2'd3
  } kind_e;

  localparam logic [1:0] E_NONE = 2'd0;
  localparam logic [1:0] E_ADDR = 2'd1;
  localparam logic [1:0] E_DATA = 2'd2;

  typedef enum logic [3:0] {
    P_IDLE, P_START, P_AHI, P_ALO, P_SUB, P_WDAT,
    P_RSTART, P_RADR, P_RDAT, P_STOP
  } phase_e;
endpackage

// File: rtl/i2cseq_addr_fmt.sv
module i2cseq_addr_fmt #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  input  logic              rd,
  output logic [7:0]        hi_byte,
  output logic [7:0]        lo_byte
);
  localparam logic [4:0] TEN_TAG = 5'b11110;

  always_comb begin
    if (ten) hi_byte = {TEN_TAG, addr[9:8], rd};
    else     hi_byte = {addr[6:0], rd};
    lo_byte = addr[7:0];
  end
endmodule

// File: rtl/i2cseq_count.sv
module i2cseq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/i2cseq_rd_hold.sv
module i2cseq_rd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] cap_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (capture) begin
      valid <= 1'b1;
      data  <= cap_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [9:0]       cmd_addr,
  input  logic             cmd_ten,
  input  logic [7:0]       cmd_sub,
  input  logic [LEN_W-1:0] cmd_len1,
  input  logic [LEN_W-1:0] cmd_len2,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             eng_cmd_valid,
  input  logic             eng_cmd_ready,
  output logic [1:0]       eng_cmd_kind,
  output logic [7:0]       eng_cmd_byte,
  output logic             eng_cmd_nack,
  input  logic             eng_rsp_valid,
  input  logic             eng_rsp_ack,
  input  logic [7:0]       eng_rsp_data,
  output logic             done,
  output logic             ok,
  output logic             present,
  output logic [1:0]       err
);
  localparam int ADDR_W = 10;

  phase_e             phase_q, phase_d;
  op_e                op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               ten_q;
  logic [7:0]         sub_q;
  logic [LEN_W-1:0]   len1_q, len2_q;
  logic               blk2_q, blk2_d;
  logic               wait_q;
  logic [1:0]         err_q, err_d;
  logic               ok_q, pres_q, pres_d, done_q;
  logic               finish;

  logic               cnt_load, cnt_dec, cnt_last;
  logic [LEN_W-1:0]   cnt_val;
  logic               capture;
  logic [7:0]         hi_byte, lo_byte;
  logic               fire, rsp, rd_take, accept;

  // block-1-complete successor
  phase_e             nb1_phase;
  logic               nb1_load;

  i2cseq_addr_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .addr(addr_q), .ten(ten_q), .rd(phase_q == P_RADR),
    .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  i2cseq_count #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  i2cseq_rd_hold #(.W(8)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_data(eng_rsp_data),
    .ready(rd_ready), .valid(rd_valid), .data(rd_data)
  );

  assign cmd_ready = (phase_q == P_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // step request towards the engine
  always_comb begin
    eng_cmd_valid = (phase_q != P_IDLE) && !wait_q;
    if (phase_q == P_WDAT) eng_cmd_valid = eng_cmd_valid && wr_valid;
    if (phase_q == P_RDAT) eng_cmd_valid = eng_cmd_valid && !rd_valid;
    unique case (phase_q)
      P_START, P_RSTART: eng_cmd_kind = K_START;
      P_STOP:            eng_cmd_kind = K_STOP;
      P_RDAT:            eng_cmd_kind = K_READ;
      default:           eng_cmd_kind = K_WRITE;
    endcase
    unique case (phase_q)
      P_AHI, P_RADR: eng_cmd_byte = hi_byte;
      P_ALO:         eng_cmd_byte = lo_byte;
      P_SUB:         eng_cmd_byte = sub_q;
      P_WDAT:        eng_cmd_byte = wr_data;
      default:       eng_cmd_byte = 8'h00;
    endcase
    eng_cmd_nack = (phase_q == P_RDAT) && cnt_last;
  end

  assign fire     = eng_cmd_valid && eng_cmd_ready;
  assign wr_ready = (phase_q == P_WDAT) && !wait_q && eng_cmd_ready;
  assign rsp      = eng_rsp_valid && wait_q;
  assign rd_take  = rd_valid && rd_ready;

  always_comb begin
    nb1_phase = P_STOP;
    nb1_load  = 1'b0;
    if (op_q == OP_WWR && len2_q != '0) begin
      nb1_phase = P_WDAT;
      nb1_load  = 1'b1;
    end else if (op_q == OP_SUBRD && len2_q != '0) begin
      nb1_phase = P_RSTART;
    end
  end

  // sequencing on each engine answer
  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = len1_q;
    cnt_dec  = 1'b0;
    blk2_d   = blk2_q;
    err_d    = err_q;
    pres_d   = pres_q;
    finish   = 1'b0;
    capture  = 1'b0;
    if (rsp) begin
      unique case (phase_q)
        P_START:  phase_d = P_AHI;
        P_AHI, P_ALO: begin
          if (!eng_rsp_ack) begin
            phase_d = P_STOP;
            err_d   = E_ADDR;
            if (op_q == OP_PROBE) pres_d = 1'b0;
          end else if (phase_q == P_AHI && ten_q) begin
            phase_d = P_ALO;
          end else begin
            unique case (op_q)
              OP_PROBE: begin
                phase_d = P_STOP;
                pres_d  = 1'b1;
              end
              OP_WRITE: begin
                if (len1_q != '0) begin
                  phase_d  = P_WDAT;
                  cnt_load = 1'b1;
                end else begin
                  phase_d = P_STOP;
                end
              end
              OP_WSUB, OP_SUBRD, OP_WWR: phase_d = P_SUB;
              default: phase_d = P_STOP;
            endcase
          end
        end
        P_SUB: begin
          if (!eng_rsp_ack) begin
            phase_d = P_STOP;
            err_d   = E_DATA;
          end else if (len1_q != '0) begin
            phase_d  = P_WDAT;
            cnt_load = 1'b1;
          end else begin
            phase_d  = nb1_phase;
            cnt_load = nb1_load;
            cnt_val  = len2_q;
            blk2_d   = nb1_load;
          end
        end
        P_WDAT: begin
          if (!eng_rsp_ack) begin
            phase_d = P_STOP;
            err_d   = E_DATA;
          end else if (!cnt_last) begin
            cnt_dec = 1'b1;
          end else if (blk2_q) begin
            phase_d = P_STOP;
          end else begin
            phase_d  = nb1_phase;
            cnt_load = nb1_load;
            cnt_val  = len2_q;
            blk2_d   = nb1_load;
          end
        end
        P_RSTART: phase_d = P_RADR;
        P_RADR: begin
          if (!eng_rsp_ack) begin
            phase_d = P_STOP;
            err_d   = E_ADDR;
          end else begin
            phase_d  = P_RDAT;
            cnt_load = 1'b1;
            cnt_val  = len2_q;
          end
        end
        P_RDAT:  capture = 1'b1;
        P_STOP: begin
          phase_d = P_IDLE;
          finish  = 1'b1;
        end
        default: phase_d = P_IDLE;
      endcase
    end else if (rd_take && phase_q == P_RDAT) begin
      if (cnt_last) phase_d = P_STOP;
      else          cnt_dec = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      op_q    <= OP_PROBE;
      addr_q  <= '0;
      ten_q   <= 1'b0;
      sub_q   <= '0;
      len1_q  <= '0;
      len2_q  <= '0;
      blk2_q  <= 1'b0;
      wait_q  <= 1'b0;
      err_q   <= E_NONE;
      ok_q    <= 1'b0;
      pres_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        phase_q <= P_START;
        op_q    <= op_e'(cmd_op);
        addr_q  <= cmd_addr;
        ten_q   <= cmd_ten;
        sub_q   <= cmd_sub;
        len1_q  <= cmd_len1;
        len2_q  <= cmd_len2;
        blk2_q  <= 1'b0;
        wait_q  <= 1'b0;
        err_q   <= E_NONE;
        ok_q    <= 1'b0;
      end else begin
        phase_q <= phase_d;
        blk2_q  <= blk2_d;
        err_q   <= err_d;
        pres_q  <= pres_d;
        if (fire)     wait_q <= 1'b1;
        else if (rsp) wait_q <= 1'b0;
        if (finish) begin
          done_q <= 1'b1;
          ok_q   <= (err_q == E_NONE);
        end
      end
    end
  end

  assign done    = done_q;
  assign ok      = ok_q;
  assign present = pres_q;
  assign err     = err_q;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       eng_cmd_valid,
  input logic       eng_cmd_ready,
  input logic [1:0] eng_cmd_kind,
  input logic [7:0] eng_cmd_byte,
  input logic       eng_rsp_valid,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       ok,
  input logic [1:0] err
);
  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              outst <= 1'b0;
    else if (eng_cmd_valid && eng_cmd_ready) outst <= 1'b1;
    else if (eng_rsp_valid)                  outst <= 1'b0;
  end

  // R13
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready |=> eng_cmd_valid && $stable(eng_cmd_kind) && $stable(eng_cmd_byte));

  // R13
  eng_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> !outst);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R11
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);

  // R9
  cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R3
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (err != 2'd0) |-> !ok);

  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && !cmd_valid |=> $stable(err));
endmodule

bind i2cseq_top i2cseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
  .eng_cmd_kind(eng_cmd_kind), .eng_cmd_byte(eng_cmd_byte),
  .eng_rsp_valid(eng_rsp_valid), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .done(done), .ok(ok), .err(err)
);

// File: tb/sim_i2cseq_top.sv
`timescale 1ns/1ps
module sim_i2cseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [9:0] cmd_addr = '0;
  logic       cmd_ten = 1'b0;
  logic [7:0] cmd_sub = '0;
  logic [7:0] cmd_len1 = '0;
  logic [7:0] cmd_len2 = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid;
  logic       rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic       eng_cmd_valid;
  logic       eng_cmd_ready = 1'b0;
  logic [1:0] eng_cmd_kind;
  logic [7:0] eng_cmd_byte;
  logic       eng_cmd_nack;
  logic       eng_rsp_valid = 1'b0;
  logic       eng_rsp_ack = 1'b0;
  logic [7:0] eng_rsp_data = '0;
  logic       done, ok, present;
  logic [1:0] err;

  always #10 clk = ~clk;

  i2cseq_top #(.LEN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_ten(cmd_ten), .cmd_sub(cmd_sub),
    .cmd_len1(cmd_len1), .cmd_len2(cmd_len2),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_kind(eng_cmd_kind), .eng_cmd_byte(eng_cmd_byte), .eng_cmd_nack(eng_cmd_nack),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ack(eng_rsp_ack), .eng_rsp_data(eng_rsp_data),
    .done(done), .ok(ok), .present(present), .err(err)
  );

  typedef struct { int kind; int byt; int nk; } step_t;
  step_t exp_q[$];
  int    wr_q[$];
  int    rd_exp_q[$];

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R0";
  int    nack_at_g = -1, wsim = 0, weng = 0, rcnt_g = 0, rbase_g = 0, lat_g = 0;
  bit    bp_g = 0, gap_g = 0, present_m = 0;
  int    cyc = 0;

  task automatic chk(bit cond, string tag, string what, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void exp_push(int kind, int byt, int nk);
    step_t s;
    s.kind = kind; s.byt = byt & 255; s.nk = nk;
    exp_q.push_back(s);
  endfunction

  function automatic bit exp_write(int byt);
    exp_push(1, byt, 0);
    exp_write = (wsim != nack_at_g);
    wsim++;
  endfunction

  // engine model: answers each step once, after a programmable delay
  initial begin
    forever begin
      @(negedge clk);
      if (eng_cmd_valid && !eng_cmd_ready) begin
        step_t s;
        int    k, b, nk;
        repeat (lat_g) @(negedge clk);
        eng_cmd_ready = 1'b1;
        k = int'(eng_cmd_kind); b = int'(eng_cmd_byte); nk = int'(eng_cmd_nack);
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected engine step", k, -1);
        end else begin
          s = exp_q.pop_front();
          chk(k == s.kind, cur_tag, "step kind", k, s.kind);
          if (s.kind == 1) chk(b == s.byt, cur_tag, "written byte", b, s.byt);
          if (s.kind == 2) chk(nk == s.nk, "R6", "read nack flag", nk, s.nk);
        end
        @(negedge clk);
        eng_cmd_ready = 1'b0;
        eng_rsp_valid = 1'b1;
        eng_rsp_ack   = 1'b1;
        eng_rsp_data  = 8'h00;
        if (k == 1) begin
          eng_rsp_ack = (weng != nack_at_g);
          weng++;
        end
        if (k == 2) begin
          eng_rsp_data = 8'((rbase_g + rcnt_g) & 255);
          rcnt_g++;
        end
        @(negedge clk);
        eng_rsp_valid = 1'b0;
      end
    end
  end

  // write stream producer: holds valid until taken
  initial begin
    forever begin
      bit took;
      @(negedge clk);
      #2;
      took = wr_valid && wr_ready;
      @(posedge clk);
      #1;
      if (took) begin
        void'(wr_q.pop_front());
        wr_valid = 1'b0;
      end
      if (!wr_valid && wr_q.size() > 0 && !(gap_g && took)) begin
        wr_valid = 1'b1;
        wr_data  = 8'(wr_q[0]);
      end
    end
  end

  // read stream consumer with optional back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid && rd_ready) begin
        if (rd_exp_q.size() == 0) chk(1'b0, "R11", "unexpected read byte", int'(rd_data), -1);
        else begin
          int e;
          e = rd_exp_q.pop_front();
          chk(int'(rd_data) == e, "R11", "read byte", int'(rd_data), e);
        end
      end
      @(posedge clk);
      #1;
      cyc++;
      rd_ready = bp_g ? (cyc % 3 == 2) : 1'b1;
    end
  end

  task automatic run_case(string tag, int op, bit ten, int addr, int sub, int l1, int l2,
                          int nk, int seed, int lat, bit bp, bit gap, bit poke);
    int  dat[$];
    int  nw, e_err, t;
    bit  live, quiet;
    int  hi, ra;
    cur_tag = tag; nack_at_g = nk; wsim = 0; weng = 0; rcnt_g = 0;
    rbase_g = (seed * 7) & 255; lat_g = lat; bp_g = bp; gap_g = gap;
    exp_q.delete(); rd_exp_q.delete();
    nw = (op == 4) ? l1 + l2 : ((op == 0) ? 0 : l1);
    for (int i = 0; i < nw; i++) dat.push_back((seed + i * 3) & 255);
    // reference step list
    e_err = 0; live = 1;
    hi = ten ? (8'hF0 | (((addr >> 8) & 3) << 1)) : ((addr & 127) << 1);
    exp_push(0, 0, 0);
    if (!exp_write(hi)) begin live = 0; e_err = 1; end
    if (live && ten && !exp_write(addr & 255)) begin live = 0; e_err = 1; end
    if (op == 0) present_m = live;
    if (live && op >= 2 && !exp_write(sub)) begin live = 0; e_err = 2; end
    for (int i = 0; i < ((op == 0) ? 0 : l1); i++)
      if (live && !exp_write(dat[i])) begin live = 0; e_err = 2; end
    if (op == 4)
      for (int i = 0; i < l2; i++)
        if (live && !exp_write(dat[l1 + i])) begin live = 0; e_err = 2; end
    if (live && op == 3 && l2 > 0) begin
      exp_push(0, 0, 0);
      ra = ten ? (8'hF1 | (((addr >> 8) & 3) << 1)) : (((addr & 127) << 1) | 1);
      if (!exp_write(ra)) begin live = 0; e_err = 1; end
      else
        for (int i = 0; i < l2; i++) begin
          exp_push(2, 0, (i == l2 - 1) ? 1 : 0);
          rd_exp_q.push_back((rbase_g + i) & 255);
        end
    end
    exp_push(3, 0, 0);
    foreach (dat[i]) wr_q.push_back(dat[i]);

    @(posedge clk); #1;
    cmd_op = 3'(op); cmd_ten = ten; cmd_addr = 10'(addr); cmd_sub = 8'(sub);
    cmd_len1 = 8'(l1); cmd_len2 = 8'(l2); cmd_valid = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "idle ready at offer", int'(cmd_ready), 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      cmd_op = 3'd0; cmd_addr = 10'h3FF; cmd_len1 = 8'd9; cmd_valid = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R9", "ready while busy", int'(cmd_ready), 0);
      @(posedge clk); #1;
      cmd_valid = 1'b0;
    end
    t = 0;
    @(negedge clk);
    while (!done && t < 4000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R12", "message finished", int'(done), 1);
    chk(int'(err) == e_err, tag, "err code", int'(err), e_err);
    chk(ok == (e_err == 0), "R12", "ok flag", int'(ok), int'(e_err == 0));
    chk(present == present_m, "R4", "present flag", int'(present), int'(present_m));
    chk(exp_q.size() == 0, tag, "steps missing", exp_q.size(), 0);
    chk(rd_exp_q.size() == 0, "R11", "read bytes missing", rd_exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done one cycle", int'(done), 0);
    quiet = 1;
    repeat (4) begin
      @(negedge clk);
      if (eng_cmd_valid) quiet = 0;
    end
    chk(quiet, "R9", "no steps after finish", int'(!quiet), 0);
    chk(int'(err) == e_err, "R8", "err held while idle", int'(err), e_err);
    wr_valid = 1'b0;
    wr_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "reset ready", int'(cmd_ready), 1);
    chk(eng_cmd_valid == 1'b0, "R13", "reset step idle", int'(eng_cmd_valid), 0);
    chk(rd_valid == 1'b0, "R11", "reset rd_valid", int'(rd_valid), 0);
    chk(done == 1'b0 && err == 2'd0, "R12", "reset status", int'({done, err}), 0);
    chk(present == 1'b0, "R4", "reset present", int'(present), 0);

    run_case("R4",  0, 0, 10'h050, 0,    0, 0, -1, 1,  0, 0, 0, 0);
    run_case("R3",  0, 0, 10'h051, 0,    0, 0,  0, 2,  1, 0, 0, 0);
    run_case("R1",  1, 0, 10'h03A, 0,    3, 0, -1, 3,  0, 0, 1, 0);
    run_case("R2",  2, 1, 10'h2A5, 8'h30, 2, 0, -1, 4, 2, 0, 1, 0);
    run_case("R3",  2, 1, 10'h1C3, 8'h11, 2, 0,  0, 5, 0, 0, 0, 0);
    run_case("R2",  1, 1, 10'h3F0, 0,    2, 0,  1, 6,  1, 0, 0, 0);
    run_case("R5",  3, 0, 10'h050, 8'h60, 0, 3, -1, 7, 0, 1, 0, 0);
    run_case("R5",  3, 1, 10'h123, 8'h44, 2, 2, -1, 8, 1, 1, 1, 0);
    run_case("R7",  4, 0, 10'h022, 8'h05, 2, 3, -1, 9, 0, 0, 1, 0);
    run_case("R8",  2, 0, 10'h033, 8'h07, 4, 0,  3, 10, 0, 0, 0, 0);
    run_case("R8",  3, 0, 10'h034, 8'h08, 1, 2,  1, 11, 1, 0, 0, 0);
    run_case("R10", 1, 0, 10'h035, 0,    0, 0, -1, 12, 0, 0, 0, 0);
    run_case("R10", 3, 0, 10'h036, 8'h09, 1, 0, -1, 13, 0, 0, 0, 0);
    run_case("R10", 4, 1, 10'h2F1, 8'h0A, 0, 2, -1, 14, 1, 0, 0, 0);
    run_case("R9",  1, 0, 10'h040, 0,    4, 0, -1, 15, 2, 0, 0, 1);
    run_case("R6",  3, 0, 10'h041, 8'h0B, 0, 1, -1, 16, 0, 1, 0, 0);
    run_case("R3",  3, 0, 10'h042, 8'h0C, 1, 2,  3, 17, 0, 0, 0, 0);
    run_case("R4",  0, 1, 10'h2B7, 0,    0, 0, -1, 18, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule